// File: doc/BRIEF.md
# Shared Instruction Cache with Per-Level Bypass

This block is a read-only, set-associative instruction cache that several cores share behind their private first-level instruction caches. A core presents a request here only after its own first level has missed. Every request carries a small field of compile-time cacheability bits, one per shared cache level, and this block looks only at the bit chosen for its level. When that bit is clear, the request is served the normal way. A hit returns the word from the local arrays. A miss fetches the whole block from memory, installs it over the least-recently-used way and updates the ages. When the bit is set, the request always goes to memory and the word is passed to the core. Nothing is installed and the set's ages stay as they were, so blocks that are never reused cannot push out blocks that are.

Access to the block is divided in time. A slot counter visits the cores in a fixed rotation, one per clock, and a core's request is taken only in its own slot while no other request is in flight. A hit answers a fixed number of cycles after acceptance. A miss or bypass issues one refill request on a simple memory port, tagged with the requesting core's index, and answers the cycle after memory replies. Three counters report how lookups were classified.

Top module: `shared_icache`

## Requirements
- R1: After reset the slot counter is 0 and advances by one each cycle, wrapping at NCORES. `reqReady[c]` is high only when the slot equals c and no request is in flight, and a request is accepted on an edge where both `reqValid[c]` and `reqReady[c]` are high.
- R2: A cacheable hit raises `rspValid[c]` for exactly one cycle, HIT_LAT cycles after the accepting edge, for the core c that issued it.
- R3: A miss or bypass drives `memReq` for one cycle, starting the cycle after acceptance. `memBlockAddr` holds the address bits above the block offset, and `memCoreTag` holds the core index. The answer appears on `rspValid` one cycle after `memRspValid`, for the core named by `memRspCore`.
- R4: A cacheable miss installs the whole block, so a later access to any word of that block hits.
- R5: Each set has NWAYS ways. The lowest-numbered invalid way is filled first, then the least-recently-used way. A hit or fill makes its way the most recent.
- R6: When bit LEVEL_SEL of the core's field in `reqNoCache` is 1, the request goes to memory even if the block is resident. Nothing is installed and the set's recency order is left unchanged.
- R7: The other bits of each core's `reqNoCache` field have no effect.
- R8: After reset all lines are invalid, all counters are 0, and `rspValid` and `memReq` are low.
- R9: Each lookup adds one to exactly one counter, one cycle after acceptance. A cacheable hit adds to `hitCount`, a cacheable miss to `missCount` and a bypass to `bypassCount`.
- R10: `rspData` is the 32-bit word chosen by address bits [4:2] of the requested block. Byte address mapping: bits [4:0] are the offset, bits [8:5] the set and bits [15:9] the tag.
- R11: Only one request is in flight at a time. No request is accepted while a hit is counting down or a refill is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NCORES | Per-core request valid |
| reqAddr | input | NCORES*ADDR_W | Per-core byte address, core c in slice c |
| reqNoCache | input | NCORES*LEVELS | Per-core cacheability bits, one per shared level |
| reqReady | output | NCORES | Core may be accepted this cycle |
| rspValid | output | NCORES | One-cycle response strobe per core |
| rspData | output | 32 | Returned instruction word |
| memReq | output | 1 | One-cycle refill request |
| memBlockAddr | output | ADDR_W-5 | Block address of the refill |
| memCoreTag | output | CORE_W | Core index sent with the refill |
| memRspValid | input | 1 | Refill data valid |
| memRspCore | input | CORE_W | Core index echoed by memory |
| memRspData | input | BLOCK_BYTES*8 | Whole block from memory |
| hitCount | output | CNT_W | Cacheable hits |
| missCount | output | CNT_W | Cacheable misses |
| bypassCount | output | CNT_W | Bypassed lookups |

## Verification
The assertions assume that memory answers only after `memReq`, sends exactly one reply per request, and echoes the core index it was given on `memRspCore`. They also assume that a core holds `reqValid` until it is accepted. The bench's memory model keeps to this: it records the tag with each request, answers once after a fixed delay and never answers unprompted. Each bench core raises its valid, waits for its own ready and drops the valid right after the accepting edge. Directed sequences fill and overflow sets, place bypasses over resident blocks and toggle the unused level bit. They run alongside a phase in which all cores press pseudo-random traffic together.

// File: rtl/icache_pkg.sv
package icache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOOK,
    ST_HITWAIT,
    ST_MEMWAIT
  } state_t;

  // Strobes from control to datapath, one per datapath action.
  typedef struct packed {
    logic capture;    // latch the granted core's address
    logic lookHit;    // take word from hit way and promote it
    logic memLoad;    // take word from refill data
    logic fill;       // install refill block into victim way
    logic incHit;
    logic incMiss;
    logic incBypass;
  } strobe_t;

endpackage

// File: rtl/icache_ctrl.sv
module icache_ctrl
  import icache_pkg::*;
#(
  parameter int NCORES    = 4,
  parameter int LEVELS    = 2,
  parameter int LEVEL_SEL = 0,
  parameter int HIT_LAT   = 10
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NCORES-1:0]                     reqValid,
  input  logic [NCORES*LEVELS-1:0]              reqNoCache,
  input  logic                                  hit,
  input  logic                                  memRspValid,
  input  logic [(NCORES > 1 ? $clog2(NCORES) : 1)-1:0] memRspCore,
  output logic [NCORES-1:0]                     reqReady,
  output logic [NCORES-1:0]                     rspValid,
  output logic                                  memReq,
  output logic [(NCORES > 1 ? $clog2(NCORES) : 1)-1:0] memCoreTag,
  output logic [(NCORES > 1 ? $clog2(NCORES) : 1)-1:0] grantCore,
  output strobe_t                               stb
);
  localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1;
  localparam int LAT_W  = $clog2(HIT_LAT + 1);

  state_t              state;
  logic [CORE_W-1:0]   slot;
  logic [CORE_W-1:0]   curCore;
  logic                curBypass;
  logic [LAT_W-1:0]    waitCnt;
  logic [NCORES-1:0]   rspValidQ;
  logic                memReqQ;
  logic                noCacheBit [NCORES];
  logic                accept;

  for (genvar c = 0; c < NCORES; c++) begin : g_level_bit
    assign noCacheBit[c] = reqNoCache[c*LEVELS + LEVEL_SEL];
  end

  always_comb begin
    reqReady = '0;
    if (state == ST_IDLE) reqReady[slot] = 1'b1;
  end

  assign accept     = (state == ST_IDLE) && reqValid[slot];
  assign grantCore  = slot;
  assign rspValid   = rspValidQ;
  assign memReq     = memReqQ;
  assign memCoreTag = curCore;

  always_comb begin
    stb           = '0;
    stb.capture   = accept;
    stb.lookHit   = (state == ST_LOOK) && hit && !curBypass;
    stb.incHit    = stb.lookHit;
    stb.incMiss   = (state == ST_LOOK) && !hit && !curBypass;
    stb.incBypass = (state == ST_LOOK) && curBypass;
    stb.memLoad   = (state == ST_MEMWAIT) && memRspValid;
    stb.fill      = stb.memLoad && !curBypass;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      slot      <= '0;
      curCore   <= '0;
      curBypass <= 1'b0;
      waitCnt   <= '0;
      rspValidQ <= '0;
      memReqQ   <= 1'b0;
    end else begin
      slot      <= (slot == CORE_W'(NCORES - 1)) ? '0 : slot + 1'b1;
      rspValidQ <= '0;
      memReqQ   <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          curCore   <= slot;
          curBypass <= noCacheBit[slot];
          state     <= ST_LOOK;
        end
        ST_LOOK: if (hit && !curBypass) begin
          waitCnt <= LAT_W'(HIT_LAT - 2);
          state   <= ST_HITWAIT;
        end else begin
          memReqQ <= 1'b1;
          state   <= ST_MEMWAIT;
        end
        ST_HITWAIT: if (waitCnt == '0) begin
          rspValidQ[curCore] <= 1'b1;
          state              <= ST_IDLE;
        end else begin
          waitCnt <= waitCnt - 1'b1;
        end
        ST_MEMWAIT: if (memRspValid) begin
          rspValidQ[memRspCore] <= 1'b1;
          state                 <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/icache_dp.sv
module icache_dp
  import icache_pkg::*;
#(
  parameter int NCORES      = 4,
  parameter int NWAYS       = 8,
  parameter int NSETS       = 16,
  parameter int BLOCK_BYTES = 32,
  parameter int ADDR_W      = 16,
  parameter int CNT_W       = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  strobe_t                               stb,
  input  logic [(NCORES > 1 ? $clog2(NCORES) : 1)-1:0] grantCore,
  input  logic [NCORES*ADDR_W-1:0]              reqAddr,
  input  logic [BLOCK_BYTES*8-1:0]              memRspData,
  output logic                                  hit,
  output logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0] memBlockAddr,
  output logic [31:0]                           rspData,
  output logic [CNT_W-1:0]                      hitCount,
  output logic [CNT_W-1:0]                      missCount,
  output logic [CNT_W-1:0]                      bypassCount
);
  localparam int WORD_W  = 32;
  localparam int OFF_W   = $clog2(BLOCK_BYTES);
  localparam int SET_W   = $clog2(NSETS);
  localparam int WAY_W   = $clog2(NWAYS);
  localparam int TAG_W   = ADDR_W - OFF_W - SET_W;
  localparam int WSEL_W  = OFF_W - 2;
  localparam int BLOCK_W = BLOCK_BYTES * 8;

  logic [ADDR_W-1:0]  curAddr;
  logic [TAG_W-1:0]   tagArr  [NSETS][NWAYS];
  logic               validArr[NSETS][NWAYS];
  logic [WAY_W-1:0]   ageArr  [NSETS][NWAYS];
  logic [BLOCK_W-1:0] dataArr [NSETS][NWAYS];

  logic [SET_W-1:0]   curSet;
  logic [TAG_W-1:0]   curTag;
  logic [WSEL_W-1:0]  curWord;
  logic [WAY_W-1:0]   hitWay, victimWay, touchWay;
  logic [WAY_W-1:0]   touchAge;
  logic               foundInv;

  assign curSet       = curAddr[OFF_W +: SET_W];
  assign curTag       = curAddr[ADDR_W-1 -: TAG_W];
  assign curWord      = curAddr[2 +: WSEL_W];
  assign memBlockAddr = curAddr[ADDR_W-1:OFF_W];

  // Tag compare and victim choice on the captured request.
  always_comb begin
    hit       = 1'b0;
    hitWay    = '0;
    victimWay = '0;
    foundInv  = 1'b0;
    for (int w = 0; w < NWAYS; w++) begin
      if (validArr[curSet][w] && tagArr[curSet][w] == curTag) begin
        hit    = 1'b1;
        hitWay = WAY_W'(w);
      end
      if (!foundInv && !validArr[curSet][w]) begin
        foundInv  = 1'b1;
        victimWay = WAY_W'(w);
      end
    end
    if (!foundInv) begin
      for (int w = 0; w < NWAYS; w++)
        if (ageArr[curSet][w] == WAY_W'(NWAYS - 1)) victimWay = WAY_W'(w);
    end
  end

  assign touchWay = stb.fill ? victimWay : hitWay;
  assign touchAge = ageArr[curSet][touchWay];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr     <= '0;
      rspData     <= '0;
      hitCount    <= '0;
      missCount   <= '0;
      bypassCount <= '0;
      for (int s = 0; s < NSETS; s++)
        for (int w = 0; w < NWAYS; w++) begin
          validArr[s][w] <= 1'b0;
          tagArr[s][w]   <= '0;
          ageArr[s][w]   <= WAY_W'(w);
        end
    end else begin
      if (stb.capture) curAddr <= reqAddr[int'(grantCore)*ADDR_W +: ADDR_W];
      if (stb.lookHit)
        rspData <= dataArr[curSet][hitWay][int'(curWord)*WORD_W +: WORD_W];
      if (stb.memLoad)
        rspData <= memRspData[int'(curWord)*WORD_W +: WORD_W];
      if (stb.fill) begin
        validArr[curSet][victimWay] <= 1'b1;
        tagArr[curSet][victimWay]   <= curTag;
      end
      if (stb.lookHit || stb.fill) begin
        for (int w = 0; w < NWAYS; w++) begin
          if (WAY_W'(w) == touchWay) ageArr[curSet][w] <= '0;
          else if (ageArr[curSet][w] < touchAge)
            ageArr[curSet][w] <= ageArr[curSet][w] + 1'b1;
        end
      end
      if (stb.incHit)    hitCount    <= hitCount + 1'b1;
      if (stb.incMiss)   missCount   <= missCount + 1'b1;
      if (stb.incBypass) bypassCount <= bypassCount + 1'b1;
    end
  end

  // Block storage, written only by refills.
  always_ff @(posedge clk) begin
    if (stb.fill) dataArr[curSet][victimWay] <= memRspData;
  end

endmodule

// File: rtl/shared_icache.sv
module shared_icache
  import icache_pkg::*;
#(
  parameter int NCORES      = 4,
  parameter int LEVELS      = 2,
  parameter int LEVEL_SEL   = 0,
  parameter int NWAYS       = 8,
  parameter int NSETS       = 16,
  parameter int BLOCK_BYTES = 32,
  parameter int ADDR_W      = 16,
  parameter int HIT_LAT     = 10,
  parameter int CNT_W       = 16
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic [NCORES-1:0]                     reqValid,
  input  logic [NCORES*ADDR_W-1:0]              reqAddr,
  input  logic [NCORES*LEVELS-1:0]              reqNoCache,
  output logic [NCORES-1:0]                     reqReady,
  output logic [NCORES-1:0]                     rspValid,
  output logic [31:0]                           rspData,
  output logic                                  memReq,
  output logic [ADDR_W-$clog2(BLOCK_BYTES)-1:0] memBlockAddr,
  output logic [(NCORES > 1 ? $clog2(NCORES) : 1)-1:0] memCoreTag,
  input  logic                                  memRspValid,
  input  logic [(NCORES > 1 ? $clog2(NCORES) : 1)-1:0] memRspCore,
  input  logic [BLOCK_BYTES*8-1:0]              memRspData,
  output logic [CNT_W-1:0]                      hitCount,
  output logic [CNT_W-1:0]                      missCount,
  output logic [CNT_W-1:0]                      bypassCount
);
  localparam int CORE_W = (NCORES > 1) ? $clog2(NCORES) : 1;

  strobe_t           stb;
  logic              hit;
  logic [CORE_W-1:0] grantCore;

  icache_ctrl #(
    .NCORES(NCORES), .LEVELS(LEVELS), .LEVEL_SEL(LEVEL_SEL), .HIT_LAT(HIT_LAT)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqNoCache(reqNoCache),
    .hit(hit), .memRspValid(memRspValid), .memRspCore(memRspCore),
    .reqReady(reqReady), .rspValid(rspValid), .memReq(memReq),
    .memCoreTag(memCoreTag), .grantCore(grantCore), .stb(stb)
  );

  icache_dp #(
    .NCORES(NCORES), .NWAYS(NWAYS), .NSETS(NSETS), .BLOCK_BYTES(BLOCK_BYTES),
    .ADDR_W(ADDR_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .grantCore(grantCore),
    .reqAddr(reqAddr), .memRspData(memRspData), .hit(hit),
    .memBlockAddr(memBlockAddr), .rspData(rspData), .hitCount(hitCount),
    .missCount(missCount), .bypassCount(bypassCount)
  );

endmodule

// File: rtl/icache_checker.sv
module icache_checker #(
  parameter int NCORES = 4,
  parameter int CNT_W  = 16
) (
  input logic                                  clk,
  input logic                                  rstN,
  input logic [NCORES-1:0]                     reqReady,
  input logic [NCORES-1:0]                     rspValid,
  input logic                                  memReq,
  input logic                                  memRspValid,
  input logic [(NCORES > 1 ? $clog2(NCORES) : 1)-1:0] memRspCore,
  input logic [(NCORES > 1 ? $clog2(NCORES) : 1)-1:0] memCoreTag,
  input logic [CNT_W-1:0]                      hitCount,
  input logic [CNT_W-1:0]                      missCount,
  input logic [CNT_W-1:0]                      bypassCount
);

  p_ready_onehot_r1: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(reqReady));

  p_rsp_onehot_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rspValid));

  p_rsp_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    (|rspValid) |=> (rspValid == '0));

  p_echo_core_r3: assert property (@(posedge clk) disable iff (!rstN)
    memRspValid |-> (memRspCore == memCoreTag));

  p_mem_pulse_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |=> !memReq);

  p_busy_no_ready_r11: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (reqReady == '0));

  p_hit_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (hitCount == $past(hitCount)) || (hitCount == $past(hitCount) + 1'b1));

  p_one_class_r9: assert property (@(posedge clk) disable iff (!rstN)
    $countones({hitCount != $past(hitCount), missCount != $past(missCount),
                bypassCount != $past(bypassCount)}) <= 1);

endmodule

bind shared_icache icache_checker #(.NCORES(NCORES), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqReady(reqReady), .rspValid(rspValid),
  .memReq(memReq), .memRspValid(memRspValid), .memRspCore(memRspCore),
  .memCoreTag(memCoreTag), .hitCount(hitCount), .missCount(missCount),
  .bypassCount(bypassCount)
);

// File: tb/shared_icache_bench.sv
`timescale 1ns/1ps
module shared_icache_bench;
  localparam int NC = 4, LV = 2, NW = 8, NS = 16, AW = 16, HL = 10;
  localparam int ML = 100, CW = 16, BW = 256, CRW = 2, BAW = AW - 5;

  logic clk = 1'b0, rstN = 1'b0;
  logic [NC-1:0]    reqValid, reqReady, rspValid;
  logic [NC*AW-1:0] reqAddr;
  logic [NC*LV-1:0] reqNoCache;
  logic [31:0]      rspData;
  logic             memReq, memRspValid;
  logic [BAW-1:0]   memBlockAddr;
  logic [CRW-1:0]   memCoreTag, memRspCore;
  logic [BW-1:0]    memRspData;
  logic [CW-1:0]    hitCount, missCount, bypassCount;

  logic          bV [NC];
  logic [AW-1:0] bA [NC];
  logic [LV-1:0] bN [NC];
  for (genvar g = 0; g < NC; g++) begin : g_drv
    assign reqValid[g]            = bV[g];
    assign reqAddr[g*AW +: AW]    = bA[g];
    assign reqNoCache[g*LV +: LV] = bN[g];
  end

  always #2.5 clk = ~clk;

  shared_icache u_shared_icache (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqAddr(reqAddr),
    .reqNoCache(reqNoCache), .reqReady(reqReady), .rspValid(rspValid),
    .rspData(rspData), .memReq(memReq), .memBlockAddr(memBlockAddr),
    .memCoreTag(memCoreTag), .memRspValid(memRspValid), .memRspCore(memRspCore),
    .memRspData(memRspData), .hitCount(hitCount), .missCount(missCount),
    .bypassCount(bypassCount)
  );

  int total = 0, bad = 0;
  bit done = 0;

  task automatic chk(bit ok, string rq, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [31:0] wordVal(int ba, int w);
    return (32'(ba) * 32'h0001_0003) ^ (32'(w) * 32'h0101_0000) ^ 32'hC3A5_0F1E;
  endfunction

  function automatic logic [AW-1:0] mk(int tag, int set, int word);
    return AW'((tag << 9) | (set << 5) | (word << 2));
  endfunction

  // ---------------- behavioural reference model ----------------
  int  cyc = 0, mSlot = 0, respEdge = 0, respCore = 0, cntEdge = 0, cntKind = 0;
  bit  busy = 0, cntPending = 0;
  logic [31:0] respWord, expData;
  logic [NC-1:0] expRsp = '0, expReady = 1;
  int  expHit = 0, expMiss = 0, expByp = 0, expBlock = 0;
  int  lruQ [NS][$];

  always @(posedge clk) begin
    if (!rstN) begin
      cyc = 0; mSlot = 0; busy = 0; cntPending = 0; expRsp = '0; expReady = 1;
      expHit = 0; expMiss = 0; expByp = 0;
      for (int s = 0; s < NS; s++) lruQ[s].delete();
    end else begin
      cyc++;
      expRsp = '0;
      if (cntPending && cyc == cntEdge) begin
        if (cntKind == 0) expHit++; else if (cntKind == 1) expMiss++; else expByp++;
        cntPending = 0;
      end
      if (!busy && bV[mSlot]) begin
        int a, set, tag, idx;
        a = int'(bA[mSlot]); set = (a >> 5) % NS; tag = a >> 9; idx = -1;
        foreach (lruQ[set][i]) if (lruQ[set][i] == tag) idx = i;
        busy = 1; respCore = mSlot; cntPending = 1; cntEdge = cyc + 1;
        respWord = wordVal(a >> 5, (a >> 2) & 7); expBlock = a >> 5;
        if (bN[mSlot][0]) begin
          cntKind = 2; respEdge = cyc + 1 + ML;
        end else if (idx >= 0) begin
          cntKind = 0; respEdge = cyc + HL;
          lruQ[set].delete(idx); lruQ[set].push_front(tag);
        end else begin
          cntKind = 1; respEdge = cyc + 1 + ML;
          lruQ[set].push_front(tag);
          if (lruQ[set].size() > NW) void'(lruQ[set].pop_back());
        end
      end else if (busy && cyc == respEdge) begin
        expRsp[respCore] = 1'b1; expData = respWord; busy = 0;
      end
      mSlot = (mSlot + 1) % NC;
      expReady = busy ? '0 : NC'(1) << mSlot;
    end
  end

  always @(negedge clk) begin
    if (rstN && !done) begin
      chk(reqReady == expReady, "R1 R11", "reqReady", reqReady, expReady);
      chk(rspValid == expRsp, "R2 R3", "rspValid", rspValid, expRsp);
      if (expRsp != '0) chk(rspData == expData, "R10", "rspData", rspData, expData);
      chk(hitCount == CW'(expHit), "R9", "hitCount", hitCount, expHit);
      chk(missCount == CW'(expMiss), "R9", "missCount", missCount, expMiss);
      chk(bypassCount == CW'(expByp), "R9", "bypassCount", bypassCount, expByp);
    end
  end

  // ---------------- memory model ----------------
  initial begin
    memRspValid = 1'b0; memRspData = '0; memRspCore = '0;
    forever begin
      @(negedge clk);
      if (rstN && memReq) begin
        int ba;
        logic [CRW-1:0] tg;
        ba = int'(memBlockAddr); tg = memCoreTag;
        chk(ba == expBlock, "R3", "memBlockAddr", ba, expBlock);
        chk(int'(tg) == respCore, "R3", "memCoreTag", tg, respCore);
        repeat (ML - 1) @(negedge clk);
        for (int w = 0; w < 8; w++) memRspData[w*32 +: 32] = wordVal(ba, w);
        memRspCore = tg; memRspValid = 1'b1;
        @(negedge clk);
        memRspValid = 1'b0;
      end
    end
  end

  // expKind: 0 hit, 1 via memory, -1 unchecked
  task automatic access(int c, logic [AW-1:0] a, logic [LV-1:0] nc, int expKind, string rq);
    int lat;
    @(negedge clk);
    bV[c] = 1'b1; bA[c] = a; bN[c] = nc;
    while (!reqReady[c]) @(negedge clk);
    @(negedge clk);
    bV[c] = 1'b0; lat = 0;
    while (!rspValid[c]) begin @(negedge clk); lat++; end
    if (expKind >= 0)
      chk(lat == ((expKind == 0) ? HL : ML + 1), rq, "latency", lat,
          (expKind == 0) ? HL : ML + 1);
  endtask

  task automatic randomRun(int c, int n);
    logic [15:0] r;
    r = 16'hACE1 + 16'(c * 977);
    for (int i = 0; i < n; i++) begin
      logic [LV-1:0] nc;
      r = {r[14:0], r[15] ^ r[13] ^ r[12] ^ r[10]};
      nc = (r[8:7] == 2'b00) ? 2'b01 : ((r[8:7] == 2'b01) ? 2'b10 : 2'b00);
      access(c, mk(int'(r[1:0]), int'(r[3:2]), int'(r[6:4])), nc, -1, "R5");
    end
  endtask

  initial begin
    for (int c = 0; c < NC; c++) begin bV[c] = 0; bA[c] = '0; bN[c] = '0; end
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    // R8: reset state
    chk(hitCount == 0 && missCount == 0 && bypassCount == 0, "R8", "counters", hitCount, 0);
    chk(rspValid == '0 && !memReq, "R8", "rspValid/memReq", {rspValid, memReq}, 0);
    chk(reqReady == 4'b0001, "R8 R1", "reqReady", reqReady, 1);

    // R4: whole block installed by a miss
    access(0, mk(1, 0, 0), 2'b00, 1, "R4");
    access(0, mk(1, 0, 7), 2'b00, 0, "R4");

    // R5: fill set 3 then overflow it
    for (int t = 0; t < 8; t++) access(1, mk(t, 3, t), 2'b00, 1, "R5");
    access(1, mk(0, 3, 1), 2'b00, 0, "R5");
    access(1, mk(8, 3, 0), 2'b00, 1, "R5");
    access(1, mk(0, 3, 2), 2'b00, 0, "R5");
    access(1, mk(1, 3, 0), 2'b00, 1, "R5");
    access(1, mk(3, 3, 4), 2'b00, 0, "R5");
    access(1, mk(2, 3, 0), 2'b00, 1, "R5");

    // R6: bypass never installs and never touches recency
    access(2, mk(2, 5, 1), 2'b01, 1, "R6");
    access(2, mk(2, 5, 1), 2'b00, 1, "R6");
    access(2, mk(2, 5, 3), 2'b00, 0, "R6");
    for (int t = 3; t < 10; t++) access(2, mk(t, 5, 0), 2'b00, 1, "R6");
    access(2, mk(2, 5, 6), 2'b01, 1, "R6");
    access(2, mk(10, 5, 0), 2'b00, 1, "R6");
    access(2, mk(2, 5, 0), 2'b00, 1, "R6");

    // R7: bit of the other level ignored
    access(3, mk(4, 7, 0), 2'b10, 1, "R7");
    access(3, mk(4, 7, 2), 2'b10, 0, "R7");

    // R1 R11: all cores at once
    fork
      access(0, mk(1, 0, 3), 2'b00, 0, "R11");
      access(1, mk(20, 9, 0), 2'b00, 1, "R11");
      access(2, mk(9, 5, 5), 2'b00, 0, "R11");
      access(3, mk(4, 7, 5), 2'b00, 0, "R11");
    join

    fork
      randomRun(0, 60);
      randomRun(1, 60);
      randomRun(2, 60);
      randomRun(3, 60);
    join

    repeat (5) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1; bad++; total++;
      $display("FAIL watchdog R11: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule